// File: doc/BRIEF.md
# Channel Source Select and Q1.15 Requantizer

This block sits in front of the stream packer in a receive path that moves four complex samples per clock. It takes three parallel sources and emits one 128-bit word per clock in a single packed Q1.15 format. The three sources are a wide channelizer output, a raw input path and a counter test pattern. Downstream logic therefore sees the same lane layout and number format whichever source is chosen.

Channelizer lanes arrive as signed 25-bit values with 23 fractional bits. Each real and imaginary part is requantized on its own. The block adds half of the lowest kept weight, shifts right arithmetically by 8 and clamps the result to the signed 16-bit range. Raw samples are already Q1.15 and pass untouched. Counter words are forwarded as given.

A two-bit select input is decoded into a named source enumeration: CHAN (0), RAW (1), COUNT (2) and ALT_RAW (3), which behaves as RAW. One output register stage gives every path the same single-clock latency. The valid flag of the selected source travels through that same stage.

Top module: `chan_source_select`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_data is all zeros, whatever the inputs are.
- R2: With sel = 0, each output part equals floor((x + 128) / 256) of the matching 25-bit signed input part x, when that value lies within -32768..32767.
- R3: With sel = 0, a part whose rounded value exceeds 32767 is output as 32767 (0x7FFF).
- R4: With sel = 0, a part whose rounded value is below -32768 is output as -32768 (0x8000).
- R5: Real and imaginary parts saturate independently: clamping one part leaves the other part's rounded value unchanged.
- R6: With sel = 1, out_data equals byp_data bit for bit.
- R7: With sel = 2, out_data equals cnt_data bit for bit.
- R8: sel = 3 behaves exactly like sel = 1 for both data and valid.
- R9: out_data and out_valid change one clock after the inputs. out_valid equals the valid of the selected source (chan_valid, byp_valid or cnt_valid), and the valids of sources that are not selected have no effect.
- R10: Lane packing: input sample k of chan_data holds its real part in bits [50k+24:50k] and its imaginary part in bits [50k+49:50k+25]. Output sample k holds its real part in bits [32k+15:32k] and its imaginary part in bits [32k+31:32k+16]. The RAW and COUNT words already use the output layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 2 | Source select: 0 CHAN, 1 RAW, 2 COUNT, 3 RAW |
| chan_data | input | 200 | Four complex channelizer samples, 25-bit signed parts |
| chan_valid | input | 1 | Channelizer word valid |
| byp_data | input | 128 | Four packed Q1.15 raw samples |
| byp_valid | input | 1 | Raw word valid |
| cnt_data | input | 128 | Four packed counter pattern samples |
| cnt_valid | input | 1 | Counter word valid |
| out_data | output | 128 | Registered packed Q1.15 output word |
| out_valid | output | 1 | Registered valid of the selected source |

## Verification
Every result is due exactly one rising edge after its inputs are applied, because the only register between input and output is the output stage. The bench drives inputs on a falling edge. It first samples 1 ns later, before the next rising edge, and confirms that the output still holds the previous step's result. It samples again 1 ns after that rising edge and compares against a value computed arithmetically from the inputs. The requantizer is swept over thousands of 25-bit values and the exact rounding and clamp thresholds. Source select is checked for all four codes, each combined with every valid pattern.

// File: rtl/srcsel_pkg.sv
package srcsel_pkg;

    typedef enum logic [1:0] {
        SRC_CHAN    = 2'd0,
        SRC_RAW     = 2'd1,
        SRC_COUNT   = 2'd2,
        SRC_ALT_RAW = 2'd3
    } src_e;

endpackage

// File: rtl/requant_lane.sv
module requant_lane #(
    parameter int IN_W  = 25,
    parameter int OUT_W = 16,
    parameter int SHIFT = 8
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int SUM_W = IN_W + 1;
    localparam logic signed [SUM_W-1:0] HALF   = SUM_W'(1) << (SHIFT - 1);
    localparam logic signed [SUM_W-1:0] MAXV   = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MINV   = ~MAXV;
    localparam logic signed [SUM_W-1:0] TOP_IN = (MAXV <<< SHIFT) - HALF;
    localparam logic signed [SUM_W-1:0] BOT_IN = (MINV <<< SHIFT) - HALF;

    logic signed [SUM_W-1:0] din_ext;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] shifted;

    always_comb begin
        din_ext = {din[IN_W-1], din};
        sum     = din_ext + HALF;
        shifted = sum >>> SHIFT;
        if (shifted > MAXV) begin
            dout = MAXV[OUT_W-1:0];
        end else if (shifted < MINV) begin
            dout = MINV[OUT_W-1:0];
        end else begin
            dout = shifted[OUT_W-1:0];
        end
    end

    always_comb begin
        if (!din[IN_W-1]) begin
            p_sign_pos_r2: assert (!dout[OUT_W-1]);
        end else begin
            p_sign_neg_r2: assert (dout[OUT_W-1] || dout == '0);
        end
        if (din_ext >= TOP_IN) begin
            p_no_overflow_r3: assert (dout == MAXV[OUT_W-1:0]);
        end
        if (din_ext <= BOT_IN) begin
            p_no_underflow_r4: assert (dout == MINV[OUT_W-1:0]);
        end
    end

endmodule

// File: rtl/chan_requant.sv
module chan_requant #(
    parameter int LANES    = 4,
    parameter int IN_W     = 25,
    parameter int IN_FRAC  = 23,
    parameter int OUT_W    = 16,
    parameter int OUT_FRAC = 15
) (
    input  logic [LANES*2*IN_W-1:0]  din,
    output logic [LANES*2*OUT_W-1:0] dout
);
    localparam int SHIFT = IN_FRAC - OUT_FRAC;
    localparam int PARTS = 2;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        for (genvar p = 0; p < PARTS; p++) begin : g_part
            logic signed [IN_W-1:0]  part_in;
            logic signed [OUT_W-1:0] part_out;
            assign part_in = din[(k*PARTS+p)*IN_W +: IN_W];
            requant_lane #(
                .IN_W  (IN_W),
                .OUT_W (OUT_W),
                .SHIFT (SHIFT)
            ) lane_i (
                .din  (part_in),
                .dout (part_out)
            );
            assign dout[(k*PARTS+p)*OUT_W +: OUT_W] = part_out;
        end
    end

endmodule

// File: rtl/pipe_reg.sv
module pipe_reg #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         d_valid,
    output logic [W-1:0] q,
    output logic         q_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q       <= d;
            q_valid <= d_valid;
        end
    end

endmodule

// File: rtl/chan_source_select.sv
module chan_source_select
    import srcsel_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int IN_W     = 25,
    parameter int IN_FRAC  = 23,
    parameter int OUT_W    = 16,
    parameter int OUT_FRAC = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                sel,
    input  logic [LANES*2*IN_W-1:0]   chan_data,
    input  logic                      chan_valid,
    input  logic [LANES*2*OUT_W-1:0]  byp_data,
    input  logic                      byp_valid,
    input  logic [LANES*2*OUT_W-1:0]  cnt_data,
    input  logic                      cnt_valid,
    output logic [LANES*2*OUT_W-1:0]  out_data,
    output logic                      out_valid
);
    localparam int WORD_W = LANES * 2 * OUT_W;

    src_e              src;
    logic [WORD_W-1:0] chan_q;
    logic [WORD_W-1:0] pick;
    logic              pick_valid;

    assign src = src_e'(sel);

    chan_requant #(
        .LANES    (LANES),
        .IN_W     (IN_W),
        .IN_FRAC  (IN_FRAC),
        .OUT_W    (OUT_W),
        .OUT_FRAC (OUT_FRAC)
    ) requant_i (
        .din  (chan_data),
        .dout (chan_q)
    );

    always_comb begin
        unique case (src)
            SRC_CHAN: begin
                pick       = chan_q;
                pick_valid = chan_valid;
            end
            SRC_COUNT: begin
                pick       = cnt_data;
                pick_valid = cnt_valid;
            end
            SRC_RAW, SRC_ALT_RAW: begin
                pick       = byp_data;
                pick_valid = byp_valid;
            end
            default: begin
                pick       = byp_data;
                pick_valid = byp_valid;
            end
        endcase
    end

    pipe_reg #(
        .W (WORD_W)
    ) out_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       (pick),
        .d_valid (pick_valid),
        .q       (out_data),
        .q_valid (out_valid)
    );

    p_raw_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd1) |=> (out_data == $past(byp_data) && out_valid == $past(byp_valid)));

    p_count_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd2) |=> (out_data == $past(cnt_data) && out_valid == $past(cnt_valid)));

    p_alt_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd3) |=> (out_data == $past(byp_data) && out_valid == $past(byp_valid)));

    p_chan_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0) |=> (out_valid == $past(chan_valid)));

endmodule

// File: tb/chan_source_select_tb_top.sv
`timescale 1ns/1ps
module chan_source_select_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic [199:0] chan_data = '0;
    logic         chan_valid = 1'b0;
    logic [127:0] byp_data = '0;
    logic         byp_valid = 1'b0;
    logic [127:0] cnt_data = '0;
    logic         cnt_valid = 1'b0;
    logic [127:0] out_data;
    logic         out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [127:0] prev_data = '0;
    logic         prev_valid = 1'b0;

    always #5 clk = ~clk;

    chan_source_select dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .chan_data  (chan_data),
        .chan_valid (chan_valid),
        .byp_data   (byp_data),
        .byp_valid  (byp_valid),
        .cnt_data   (cnt_data),
        .cnt_valid  (cnt_valid),
        .out_data   (out_data),
        .out_valid  (out_valid)
    );

    function automatic logic [15:0] q15(longint x);
        longint r;
        r = (x + 128) >>> 8;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r[15:0];
    endfunction

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on falling edge, confirm hold before the rising edge, then check after it.
    task automatic step(logic [1:0] s, logic [199:0] cd, logic cv, logic [127:0] bd, logic bv,
                        logic [127:0] nd, logic nv, logic [127:0] ed, logic ev, string tag);
        @(negedge clk);
        sel = s; chan_data = cd; chan_valid = cv;
        byp_data = bd; byp_valid = bv; cnt_data = nd; cnt_valid = nv;
        #1;
        chk(out_data == prev_data && out_valid == prev_valid, "R9 hold before edge",
            {out_valid, out_data[126:0]}, {prev_valid, prev_data[126:0]});
        @(posedge clk);
        #1;
        chk(out_data == ed, tag, out_data, ed);
        chk(out_valid == ev, {tag, " valid"}, 128'(out_valid), 128'(ev));
        prev_data = ed;
        prev_valid = ev;
    endtask

    // Channel step: real/imag values per lane, expected via arithmetic (R2 R10).
    task automatic chan_step(longint xs[8], string tag);
        logic [199:0] cd;
        logic [127:0] ed;
        for (int i = 0; i < 8; i++) begin
            logic [24:0] v;
            v = xs[i][24:0];
            cd[25*i +: 25] = v;
            ed[16*i +: 16] = q15(xs[i]);
        end
        step(2'd0, cd, 1'b1, 128'h0, 1'b0, 128'h0, 1'b0, ed, 1'b1, tag);
    endtask

    initial begin
        longint xs[8];
        longint bnd[16];
        logic [127:0] pat;
        // R1: reset holds outputs at zero with active inputs
        sel = 2'd1; byp_data = {4{32'hDEAD_BEEF}}; byp_valid = 1'b1; chan_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(out_data == '0, "R1 reset data", out_data, 128'h0);
        chk(out_valid == 1'b0, "R1 reset valid", 128'(out_valid), 128'h0);
        @(negedge clk);
        sel = 2'd0; byp_valid = 1'b0; chan_valid = 1'b0; byp_data = '0;
        rst_n = 1'b1;

        // R2 R10: sweep of the 25-bit range, real/imag in distinct lanes
        for (int n = 0; n < 1500; n++) begin
            for (int i = 0; i < 8; i++) begin
                longint idx;
                idx = longint'(n) * 8 + i;
                xs[i] = ((idx * 4099 + i * 977) % 33554432) - 16777216;
            end
            chan_step(xs, "R2 sweep");
        end

        // R3 R4: thresholds of rounding and clamping
        bnd = '{127, 128, -128, -129, 8388479, 8388480, 8388607, 16777215,
                -8388736, -8388737, -16777216, 255, 383, -385, -384, 0};
        for (int n = 0; n < 2; n++) begin
            for (int i = 0; i < 8; i++) xs[i] = bnd[n*8 + i];
            chan_step(xs, n == 0 ? "R3 R2 thresholds" : "R4 R2 thresholds");
        end
        // R3: direct upper clamp value check
        for (int i = 0; i < 8; i++) xs[i] = 16777215 - i * 1000;
        chan_step(xs, "R3 clamp high");
        chk(out_data[15:0] == 16'h7FFF, "R3 lane0 real", 128'(out_data[15:0]), 128'h7FFF);
        // R4: direct lower clamp value check
        for (int i = 0; i < 8; i++) xs[i] = -16777216 + i * 1000;
        chan_step(xs, "R4 clamp low");
        chk(out_data[31:16] == 16'h8000, "R4 lane0 imag", 128'(out_data[31:16]), 128'h8000);

        // R5: one part clamped, the other in range
        for (int i = 0; i < 8; i++) xs[i] = (i % 2 == 0) ? 16777000 : -1000 * i - 200;
        chan_step(xs, "R5 real clamp imag free");
        for (int i = 0; i < 8; i++) xs[i] = (i % 2 == 1) ? -16777000 : 5000 * i + 129;
        chan_step(xs, "R5 imag clamp real free");
        chk(out_data[15:0] == q15(129), "R5 lane0 real kept", 128'(out_data[15:0]), 128'(q15(129)));

        // R6 R7 R8 R9: every select code with every valid pattern
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 8; v++) begin
                logic [127:0] bd, nd, ed;
                logic [199:0] cd;
                logic ev;
                bd = {4{32'hA5A5_0000 | 32'(s*16 + v)}} ^ {32'(v), 96'h0};
                for (int k = 0; k < 4; k++) nd[32*k +: 32] = {16'(v), 16'(k + 4*s)};
                cd = '0;
                for (int k = 0; k < 8; k++) cd[25*k +: 25] = 25'(k * 256);
                case (s)
                    0: begin
                        for (int k = 0; k < 8; k++) ed[16*k +: 16] = 16'(k);
                        ev = v[0];
                    end
                    2: begin ed = nd; ev = v[2]; end
                    default: begin ed = bd; ev = v[1]; end
                endcase
                step(2'(s), cd, v[0], bd, v[1], nd, v[2], ed, ev,
                     s == 0 ? "R9 chan select" : s == 1 ? "R6 raw select" :
                     s == 2 ? "R7 count select" : "R8 alt raw select");
            end
        end

        // R6: bypass keeps full-scale and sign bits untouched
        pat = {32'h8000_7FFF, 32'hFFFF_0001, 32'h7FFF_8000, 32'h0000_FFFF};
        step(2'd1, '1, 1'b1, pat, 1'b1, '0, 1'b0, pat, 1'b1, "R6 raw extremes");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule